// File: doc/BRIEF.md
# Serial Management Bus Master (Clause 22)

This block is a master for the two-wire station management bus used to reach Ethernet PHY registers. Software controls it through one 32-bit register. That register holds the launch/busy flag, the direction, the 5-bit PHY address, the 5-bit register address and a 16-bit data field. Each launch runs exactly one Clause 22 frame. The block divides the system clock down to produce the management clock, and it drives or releases the data line as the frame requires. For a read, it shifts the PHY's answer back into the low half of the same register.

A host typically writes the command fields with the launch flag clear. It then writes the same word again with the flag set, and polls the flag until it drops. Host writes that arrive while a frame is in flight are discarded, so a second command cannot corrupt the running one. At the default divisor, a full frame takes 64 management-clock periods of 50 system cycles each, about 26 µs at 125 MHz. That is far inside a one-millisecond polling budget.

Top module: `mdio_master`

## Requirements
- R1: After reset, the register reads 0x00000000, `mdc` is low, and `mdio_oe` is low. Whenever no frame is in progress, `mdio_oe` stays low.
- R2: A host write with bit 31 clear starts no frame. Busy stays 0, `mdc` stays low, and the register reads back bit 30 (1 = write to PHY, 0 = read), the PHY address in bits 28:24, the register address in bits 20:16 and the data in bits 15:0.
- R3: A host write with bit 31 set while idle starts a frame. Bit 31 reads 1 from the next cycle until the frame ends, then returns to 0.
- R4: A write frame sends, MSB first, on consecutive MDC periods: 32 ones, start code 01, opcode 01, the PHY address, the register address, turnaround 10, then the 16 data bits, all with `mdio_oe` high.
- R5: A read frame sends 32 ones, start code 01, opcode 10 and the two addresses. It then holds `mdio_oe` low for the two turnaround bits and the 16 data bits.
- R6: On a read, `mdio_i` is sampled once per data bit during the MDC high phase. The 16 samples, MSB first, appear in bits 15:0 in the same cycle busy clears. With no responder and a pulled-up line, this value is 0xFFFF.
- R7: A host write that arrives while busy is 1 changes none of the register's fields and does not alter the frame in flight.
- R8: Each MDC half period lasts `MDC_HALF` system cycles (default 25, i.e. 2.5 MHz at 125 MHz). `mdio_o` and `mdio_oe` change only while `mdc` is low. A frame holds busy for about 64 MDC periods.
- R9: Bits 29 and 23:21 always read as zero, whatever was written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Register write strobe, one cycle per write |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Register read value (busy, direction, addresses, data) |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | Management data line as seen at the pad |
| mdio_o | output | 1 | Management data driven by the master |
| mdio_oe | output | 1 | Output enable for `mdio_o`; low releases the line |

## Verification
The assertions assume that `host_wr` is a single-cycle strobe sampled at the clock edge. They also assume that `mdio_i` changes only near MDC falling edges, never in the high phase where it is sampled. The bench drives every host write as a one-cycle pulse set up at the falling system-clock edge. Its PHY model updates the line only on MDC falling edges, and it feeds the DUT the resolved line: the master's bit while enabled, otherwise the PHY's value or the pull-up.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int FRAME_BITS = 64;
    localparam int TA_FIRST   = 46;   // position of first turnaround bit in frame
    localparam int DATA_FIRST = 48;   // position of first data bit in frame

    typedef enum logic [1:0] {
        OPC_WRITE = 2'b01,
        OPC_READ  = 2'b10
    } mdio_opc_e;

    typedef struct packed {
        logic        is_wr;
        logic [4:0]  phy;
        logic [4:0]  regn;
        logic [15:0] data;
    } mdio_cmd_t;

    function automatic mdio_cmd_t cmd_from_word(logic [31:0] w);
        mdio_cmd_t c;
        c.is_wr = w[30];
        c.phy   = w[28:24];
        c.regn  = w[20:16];
        c.data  = w[15:0];
        return c;
    endfunction

    function automatic logic [31:0] word_from_cmd(logic busy, mdio_cmd_t c);
        return {busy, c.is_wr, 1'b0, c.phy, 3'b000, c.regn, c.data};
    endfunction

    function automatic logic [FRAME_BITS-1:0] frame_from_cmd(mdio_cmd_t c);
        mdio_opc_e opc;
        opc = c.is_wr ? OPC_WRITE : OPC_READ;
        return {32'hFFFF_FFFF, 2'b01, opc, c.phy, c.regn, 2'b10, c.data};
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int HALF = 25
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic mdc,
    output logic drive_tick,
    output logic sample_tick
);
    localparam int CW       = (HALF < 2) ? 1 : $clog2(HALF);
    localparam int DRIVE_AT = HALF / 2;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt         <= '0;
            mdc         <= 1'b0;
            drive_tick  <= 1'b0;
            sample_tick <= 1'b0;
        end else begin
            drive_tick  <= !mdc && (cnt == CW'(DRIVE_AT));
            sample_tick <= 1'b0;
            if (cnt == CW'(HALF - 1)) begin
                cnt         <= '0;
                mdc         <= ~mdc;
                sample_tick <= !mdc;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R8: a drive slot only ever falls inside the low phase
    assert_drive_in_low_R8: assert property (@(posedge clk) disable iff (rst)
        drive_tick |-> !mdc);

endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  mdio_cmd_t   cmd,
    input  logic        drive_tick,
    input  logic        sample_tick,
    input  logic        mdio_i,
    output logic        run,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        done,
    output logic [15:0] rd_data
);
    logic [FRAME_BITS-1:0] sh;
    logic [6:0]            cnt;
    logic                  is_wr;
    logic                  active;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh      <= '0;
            cnt     <= '0;
            is_wr   <= 1'b0;
            active  <= 1'b0;
            mdio_o  <= 1'b0;
            mdio_oe <= 1'b0;
            done    <= 1'b0;
            rd_data <= '0;
        end else begin
            done <= 1'b0;
            if (start && !active) begin
                active <= 1'b1;
                sh     <= frame_from_cmd(cmd);
                cnt    <= '0;
                is_wr  <= cmd.is_wr;
            end else if (active) begin
                if (drive_tick) begin
                    if (cnt == 7'(FRAME_BITS)) begin
                        active  <= 1'b0;
                        mdio_oe <= 1'b0;
                        mdio_o  <= 1'b0;
                        done    <= 1'b1;
                    end else begin
                        mdio_o  <= sh[FRAME_BITS-1];
                        mdio_oe <= is_wr || (cnt < 7'(TA_FIRST));
                        sh      <= {sh[FRAME_BITS-2:0], 1'b0};
                        cnt     <= cnt + 1'b1;
                    end
                end
                if (sample_tick && !is_wr && (cnt > 7'(DATA_FIRST))) begin
                    rd_data <= {rd_data[14:0], mdio_i};
                end
            end
        end
    end

    assign run = active;

    // R5: line released from the turnaround onward on reads
    assert_read_release_R5: assert property (@(posedge clk) disable iff (rst)
        active && !is_wr && (cnt > 7'(TA_FIRST)) |-> !mdio_oe);

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int MDC_HALF = 25
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_wr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        mdc,
    input  logic        mdio_i,
    output logic        mdio_o,
    output logic        mdio_oe
);
    localparam int HALF_EFF = (MDC_HALF < 2) ? 2 : MDC_HALF;

    mdio_cmd_t   cmd_q;
    logic        busy_q;
    logic        start;
    logic        run;
    logic        drive_tick;
    logic        sample_tick;
    logic        done;
    logic [15:0] rd_data;

    assign start = host_wr && !busy_q && host_wdata[31];

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            busy_q <= 1'b0;
        end else if (done) begin
            busy_q <= 1'b0;
            if (!cmd_q.is_wr) cmd_q.data <= rd_data;
        end else if (host_wr && !busy_q) begin
            cmd_q  <= cmd_from_word(host_wdata);
            busy_q <= host_wdata[31];
        end
    end

    assign host_rdata = word_from_cmd(busy_q, cmd_q);

    mdio_clkgen #(.HALF(HALF_EFF)) u_clk (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .mdc        (mdc),
        .drive_tick (drive_tick),
        .sample_tick(sample_tick)
    );

    mdio_shifter u_shift (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .cmd        (cmd_from_word(host_wdata)),
        .drive_tick (drive_tick),
        .sample_tick(sample_tick),
        .mdio_i     (mdio_i),
        .run        (run),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe),
        .done       (done),
        .rd_data    (rd_data)
    );

    assert_idle_release_R1: assert property (@(posedge clk) disable iff (rst)
        !host_rdata[31] |-> !mdio_oe);

    assert_start_busy_R3: assert property (@(posedge clk) disable iff (rst)
        host_wr && host_wdata[31] && !host_rdata[31] |=> host_rdata[31]);

    assert_ignore_busy_R7: assert property (@(posedge clk) disable iff (rst)
        host_rdata[31] && host_wr && !done |=> $stable(host_rdata[30:0]));

    assert_change_low_R8: assert property (@(posedge clk) disable iff (rst)
        (!$stable(mdio_o) || !$stable(mdio_oe)) |-> !mdc);

    assert_done_when_busy_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> host_rdata[31]);

endmodule

// File: tb/sim_mdio_master.sv
`timescale 1ns/1ps
module sim_mdio_master;
    localparam int HALF = 25;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        phy_val = 1'b1;
    logic        mdio_i;

    assign mdio_i = mdio_oe ? mdio_o : phy_val;

    always #4 clk = ~clk;

    mdio_master #(.MDC_HALF(HALF)) u0 (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .mdc(mdc), .mdio_i(mdio_i),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    // PHY model and frame recorder
    int          rise_cnt = 0;
    logic [63:0] frame_cap = '0;
    bit          phy_en = 1'b0;
    logic [15:0] phy_resp = '0;
    int          cyc = 0;
    int          last_rise = 0;
    int          min_gap = 1000000;

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge mdc) begin
        frame_cap = {frame_cap[62:0], mdio_i};
        rise_cnt  = rise_cnt + 1;
        if (rise_cnt > 1 && (cyc - last_rise) < min_gap) min_gap = cyc - last_rise;
        last_rise = cyc;
    end

    always @(negedge mdc) begin
        if (phy_en && rise_cnt == 47) phy_val = 1'b0;
        else if (phy_en && rise_cnt >= 48 && rise_cnt < 64) phy_val = phy_resp[63 - rise_cnt];
        else phy_val = 1'b1;
    end

    localparam logic [31:0] VEC_CMD  [4] = '{32'h4100_A5C3, 32'h0302_0000, 32'h7F9F_0001, 32'h1001_0000};
    localparam logic [15:0] VEC_RESP [4] = '{16'h0000, 16'h1234, 16'h0000, 16'hFEDC};

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic host_write(input logic [31:0] w);
        @(negedge clk);
        host_wr = 1'b1;
        host_wdata = w;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic wait_idle(output int cycles);
        cycles = 1;
        while (host_rdata[31] && cycles < 10000) begin
            @(negedge clk);
            cycles++;
        end
    endtask

    function automatic logic [63:0] exp_frame(logic [31:0] c, logic [15:0] resp, bit present);
        logic [1:0]  opc;
        logic [1:0]  ta;
        logic [15:0] d;
        opc = c[30] ? 2'b01 : 2'b10;
        ta  = (c[30] || present) ? 2'b10 : 2'b11;
        d   = c[30] ? c[15:0] : (present ? resp : 16'hFFFF);
        return {32'hFFFF_FFFF, 2'b01, opc, c[28:24], c[20:16], ta, d};
    endfunction

    task automatic arm(input logic [15:0] resp, input bit en);
        rise_cnt  = 0;
        frame_cap = '0;
        phy_resp  = resp;
        phy_en    = en;
        phy_val   = 1'b1;
    endtask

    initial begin
        int cycles;
        logic [31:0] stage;
        logic [31:0] expw;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(host_rdata == 32'h0, "R1 reset register", {32'h0, host_rdata}, 64'h0);
        check(mdc == 1'b0 && mdio_oe == 1'b0, "R1 reset lines", {62'h0, mdc, mdio_oe}, 64'h0);

        // Vector table walk
        for (int i = 0; i < 4; i++) begin
            stage = VEC_CMD[i] & 32'h5F1F_FFFF;
            host_write(VEC_CMD[i]);
            check(host_rdata == stage, "R2/R9 staged readback", {32'h0, host_rdata}, {32'h0, stage});
            arm(VEC_RESP[i], 1'b1);
            host_write(VEC_CMD[i] | 32'h8000_0000);
            check(host_rdata[31] == 1'b1, "R3 busy set", {63'h0, host_rdata[31]}, 64'h1);
            wait_idle(cycles);
            check(host_rdata[31] == 1'b0, "R3 busy clears", {63'h0, host_rdata[31]}, 64'h0);
            check(frame_cap == exp_frame(VEC_CMD[i], VEC_RESP[i], 1'b1),
                  VEC_CMD[i][30] ? "R4 write frame" : "R5 read frame",
                  frame_cap, exp_frame(VEC_CMD[i], VEC_RESP[i], 1'b1));
            expw = VEC_CMD[i][30] ? stage : {stage[31:16], VEC_RESP[i]};
            check(host_rdata == expw, "R6 result word", {32'h0, host_rdata}, {32'h0, expw});
            check(cycles >= 63*2*HALF && cycles <= 66*2*HALF, "R8 frame duration",
                  64'(cycles), 64'(64*2*HALF));
        end

        // R2: staging write alone does not start anything
        host_write(32'h0304_0000);
        begin
            bit moved = 0;
            for (int k = 0; k < 200; k++) begin
                @(negedge clk);
                if (mdc || host_rdata[31]) moved = 1;
            end
            check(!moved, "R2 no launch without bit 31", {63'h0, moved}, 64'h0);
        end

        // R7: write while busy ignored
        arm(16'h0F0F, 1'b1);
        host_write(32'h8507_0000);
        repeat (40) @(negedge clk);
        host_write(32'hC1E2_3333);
        check(host_rdata == 32'h8507_0000, "R7 fields kept while busy",
              {32'h0, host_rdata}, 64'h8507_0000);
        wait_idle(cycles);
        check(frame_cap == exp_frame(32'h0507_0000, 16'h0F0F, 1'b1), "R7 frame unaffected",
              frame_cap, exp_frame(32'h0507_0000, 16'h0F0F, 1'b1));
        check(host_rdata == 32'h0507_0F0F, "R7 result after ignored write",
              {32'h0, host_rdata}, 64'h0507_0F0F);

        // R6: no responder, pull-up gives all ones
        arm(16'h0000, 1'b0);
        host_write(32'h8203_0000);
        wait_idle(cycles);
        check(host_rdata == 32'h0203_FFFF, "R6 no responder reads 0xFFFF",
              {32'h0, host_rdata}, 64'h0203_FFFF);
        check(frame_cap == exp_frame(32'h0203_0000, 16'h0, 1'b0), "R5 released turnaround",
              frame_cap, exp_frame(32'h0203_0000, 16'h0, 1'b0));

        // R8: MDC period, R1: idle release
        check(min_gap >= 2*HALF, "R8 MDC period", 64'(min_gap), 64'(2*HALF));
        check(mdio_oe == 1'b0 && mdc == 1'b0, "R1 idle lines", {62'h0, mdc, mdio_oe}, 64'h0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule